// File: doc/BRIEF.md
# Page Write Buffer with Guarded Commit

This block gathers one page of write data for a byte-addressed nonvolatile store. It then copies that data into the store during a self-timed busy period. Software first arms a write-enable latch. It then gives a starting byte address and streams in data bytes. Each byte lands at the next offset inside a fixed 32-byte page, and offsets past the top of the page wrap back to its first byte. When a commit is requested and the latch is armed, the block lowers its ready flag for a fixed number of clock cycles. During that time it emits one storage write per loaded byte, in ascending offset order, on a simple write port toward a behavioural array.

A write-protect input held low keeps the latch clear, so no new commit can start. Dropping it while a commit runs leaves that commit intact. The latch also clears at the end of every commit, after any invalid write and on reset. After reset, two hold-off windows are counted in clock cycles. The read window is only reported. The write window gates every write-side strobe. All timing constants are parameters in clock cycles, so a simulation can use short values.

Top module: `pgbuf_commit`

## Requirements
- R1: A loaded address selects the page `addr_in >> 5` and sets the load offset to `addr_in[4:0]`. Every storage write of a commit goes to `page*32 + offset`.
- R2: Each accepted data byte goes into the current offset, which then advances modulo 32. A 33rd byte therefore overwrites the position of the first one, and the last value written to an offset is the one committed.
- R3: A commit writes only the offsets loaded since the last address load or commit end, one per cycle, in ascending offset order. The first write appears the cycle after ready falls. The loaded-byte mask is cleared at commit end, but the page and offset are kept.
- R4: A commit request starts only when the latch is set, the unlock input is high, an address has been loaded and at least one byte is loaded. Otherwise nothing is written, ready stays 1, the latch clears and the loaded bytes are discarded.
- R5: `arm_req` sets the latch only while `wr_unlock` is 1. The latch reads 0 in every cycle after one in which `wr_unlock` was 0.
- R6: `ready_o` is 1 when idle. It goes to 0 on the edge that accepts a commit, stays 0 for exactly BUSY_CYC cycles and then returns to 1 with the latch clear.
- R7: Lowering `wr_unlock` during a commit neither shortens it nor drops any of its writes. A later commit request with `wr_unlock` low does not start.
- R8: `rd_ok_o` rises after RD_HOLD_CYC clock edges following reset and `wr_ok_o` after WR_HOLD_CYC edges. Until `wr_ok_o` is 1, arm, address, data and commit strobes are ignored.
- R9: An invalid write clears the latch and discards the loaded bytes. An invalid write is either `bad_wr`, or a data byte arriving when no address has been loaded since reset.
- R10: While `ready_o` is 0, arm, address, data and commit strobes have no effect on the latch, the page, the offset or the loaded bytes.
- R11: In reset, and on the first cycle after it, ready is 1 while the latch, both hold-off flags and the storage write enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| wr_unlock | input | 1 | 1 allows writes; 0 clears and holds the latch clear |
| arm_req | input | 1 | Request to set the write-enable latch |
| addr_vld | input | 1 | Load `addr_in` as page and starting offset |
| addr_in | input | ADDR_W | Starting byte address |
| dat_vld | input | 1 | Load `dat_in` at the current offset |
| dat_in | input | 8 | Data byte |
| commit_req | input | 1 | Request to start the commit |
| bad_wr | input | 1 | Invalid-write indication from the upstream decoder |
| ready_o | output | 1 | 0 while a commit runs, 1 otherwise |
| wel_o | output | 1 | Write-enable latch state |
| rd_ok_o | output | 1 | Read hold-off window has elapsed |
| wr_ok_o | output | 1 | Write hold-off window has elapsed |
| mem_we_o | output | 1 | Storage write strobe |
| mem_addr_o | output | ADDR_W | Storage write address |
| mem_wdata_o | output | 8 | Storage write data |

## Verification
The properties assume that `wr_unlock` has a defined level from reset onward. They also assume that BUSY_CYC is larger than the page size and that RD_HOLD_CYC does not exceed WR_HOLD_CYC. Without these, ordering and timing claims such as writes only during busy, or read clearance before write clearance, do not hold. The stimulus keeps the unlock input steady across reset and uses a configuration that meets both parameter relations. It raises at most one strobe per cycle, so results never depend on the priority among coincident strobes. It sweeps every starting offset of the page with varied byte counts, plus a wrapping load longer than the page.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  localparam int BYTE_W = 8;

  // decoded, mutually consistent write-side events for one cycle
  typedef struct packed {
    logic inval;
    logic start;
    logic fail;
    logic arm;
    logic ld_addr;
    logic ld_dat;
  } ctl_t;
endpackage

// File: rtl/pgb_powerup.sv
module pgb_powerup #(
  parameter int RD_HOLD_CYC = 200000,
  parameter int WR_HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  output logic rd_ok,
  output logic wr_ok
);
  localparam int CW = $clog2(WR_HOLD_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      rd_ok <= 1'b0;
      wr_ok <= 1'b0;
    end else begin
      if (cnt != CW'(WR_HOLD_CYC)) cnt <= cnt + 1'b1;
      if (cnt == CW'(RD_HOLD_CYC - 1)) rd_ok <= 1'b1;
      if (cnt == CW'(WR_HOLD_CYC - 1)) wr_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/pgb_timer.sv
module pgb_timer #(
  parameter int BUSY_CYC   = 500000,
  parameter int PAGE_BYTES = 32,
  localparam int OW = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          ready,
  output logic          scan_en,
  output logic [OW-1:0] scan_idx,
  output logic          finish
);
  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  // the busy counter doubles as the page scan index
  assign finish   = !ready && (cnt == CW'(BUSY_CYC - 1));
  assign scan_en  = !ready && (cnt < CW'(PAGE_BYTES));
  assign scan_idx = cnt[OW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else if (ready) begin
      if (start) begin
        ready <= 1'b0;
        cnt   <= '0;
      end
    end else if (finish) begin
      ready <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pgb_page_ram.sv
module pgb_page_ram
  import pgb_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 14,
  localparam int OW = $clog2(PAGE_BYTES),
  localparam int PW = ADDR_W - OW
) (
  input  logic              clk,
  input  logic              rst,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [BYTE_W-1:0] dat_in,
  input  logic              scan_en,
  input  logic [OW-1:0]     scan_idx,
  input  logic              finish,
  output logic              have_addr,
  output logic              any_vld,
  output logic [PW-1:0]     page_q,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_we,
  output logic [OW-1:0]     rd_off
);
  logic [BYTE_W-1:0]     ram [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [OW-1:0]         ptr;

  assign any_vld = |vld;

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (ctl.ld_dat) ram[ptr] <= dat_in;
    rd_byte <= ram[scan_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      page_q    <= '0;
      have_addr <= 1'b0;
    end else if (ctl.ld_addr) begin
      ptr       <= addr_in[OW-1:0];
      page_q    <= addr_in[ADDR_W-1:OW];
      have_addr <= 1'b1;
    end else if (ctl.ld_dat) begin
      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (ctl.inval || ctl.fail || finish || ctl.ld_addr) begin
      vld <= '0;
    end else if (ctl.ld_dat) begin
      vld[ptr] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_we  <= 1'b0;
      rd_off <= '0;
    end else begin
      rd_we  <= scan_en && vld[scan_idx];
      rd_off <= scan_idx;
    end
  end
endmodule

// File: rtl/pgb_wel.sv
module pgb_wel (
  input  logic clk,
  input  logic rst,
  input  logic unlock,
  input  logic arm,
  input  logic clr,
  output logic wel
);
  always_ff @(posedge clk) begin
    if (rst || !unlock || clr) wel <= 1'b0;
    else if (arm)              wel <= 1'b1;
  end
endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgb_pkg::*;
#(
  parameter int PAGE_BYTES  = 32,
  parameter int ADDR_W      = 14,
  parameter int BUSY_CYC    = 500000,
  parameter int RD_HOLD_CYC = 200000,
  parameter int WR_HOLD_CYC = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_unlock,
  input  logic              arm_req,
  input  logic              addr_vld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              dat_vld,
  input  logic [7:0]        dat_in,
  input  logic              commit_req,
  input  logic              bad_wr,
  output logic              ready_o,
  output logic              wel_o,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int PW = ADDR_W - OW;

  ctl_t          ctl;
  logic          acc, cmt, ok, have_addr, any_vld;
  logic          scan_en, finish;
  logic [OW-1:0] scan_idx, rd_off;
  logic [PW-1:0] page_q;

  pgb_powerup #(.RD_HOLD_CYC(RD_HOLD_CYC), .WR_HOLD_CYC(WR_HOLD_CYC)) u_pwr (
    .clk(clk), .rst(rst), .rd_ok(rd_ok_o), .wr_ok(wr_ok_o)
  );

  // write-side event decode: one winner per cycle
  always_comb begin
    acc         = wr_ok_o && ready_o;
    ctl.inval   = acc && (bad_wr || (dat_vld && !have_addr));
    cmt         = acc && commit_req && !ctl.inval;
    ok          = wel_o && wr_unlock && have_addr && any_vld;
    ctl.start   = cmt && ok;
    ctl.fail    = cmt && !ok;
    ctl.arm     = acc && arm_req && wr_unlock && !ctl.inval && !cmt;
    ctl.ld_addr = acc && addr_vld && !ctl.inval && !cmt;
    ctl.ld_dat  = acc && dat_vld && have_addr && !ctl.inval && !cmt && !addr_vld;
  end

  pgb_wel u_wel (
    .clk(clk), .rst(rst), .unlock(wr_unlock), .arm(ctl.arm),
    .clr(ctl.inval || ctl.fail || finish), .wel(wel_o)
  );

  pgb_timer #(.BUSY_CYC(BUSY_CYC), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk(clk), .rst(rst), .start(ctl.start), .ready(ready_o),
    .scan_en(scan_en), .scan_idx(scan_idx), .finish(finish)
  );

  pgb_page_ram #(.PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .rst(rst), .ctl(ctl), .addr_in(addr_in), .dat_in(dat_in),
    .scan_en(scan_en), .scan_idx(scan_idx), .finish(finish),
    .have_addr(have_addr), .any_vld(any_vld), .page_q(page_q),
    .rd_byte(mem_wdata_o), .rd_we(mem_we_o), .rd_off(rd_off)
  );

  assign mem_addr_o = {page_q, rd_off};
endmodule

// File: rtl/pgb_checker.sv
module pgb_checker #(
  parameter int PAGE_BYTES = 32,
  parameter int ADDR_W     = 14,
  parameter int BUSY_CYC   = 500000
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_unlock,
  input logic              ready_o,
  input logic              wel_o,
  input logic              rd_ok_o,
  input logic              wr_ok_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int OW = $clog2(PAGE_BYTES);
  localparam int BW = $clog2(BUSY_CYC + 2);

  logic [BW-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst || ready_o) busy_len <= '0;
    else                busy_len <= busy_len + 1'b1;
  end

  AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> !ready_o); // R3
  AST_PAGE_ORDER: assert property (@(posedge clk) disable iff (rst)
    mem_we_o && $past(mem_we_o) |->
      (mem_addr_o[ADDR_W-1:OW] == $past(mem_addr_o[ADDR_W-1:OW])) &&
      (mem_addr_o[OW-1:0] > $past(mem_addr_o[OW-1:0]))); // R1
  AST_START_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
    $fell(ready_o) |-> $past(wel_o) && $past(wr_unlock)); // R4
  AST_UNLOCK_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_unlock) |-> !wel_o); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> busy_len == BW'(BUSY_CYC)); // R6
  AST_LATCH_CLEAR_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> !wel_o); // R6
  AST_HOLD_ORDER: assert property (@(posedge clk) disable iff (rst)
    wr_ok_o |-> rd_ok_o); // R8
  AST_NO_WRITE_BEFORE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ok_o |-> ready_o && !wel_o); // R8
endmodule

bind pgbuf_commit pgb_checker #(
  .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)
) u_pgb_checker (
  .clk(clk), .rst(rst), .wr_unlock(wr_unlock), .ready_o(ready_o),
  .wel_o(wel_o), .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
);

// File: tb/pgbuf_commit_bench.sv
module pgbuf_commit_bench;
  localparam int PG   = 32;
  localparam int AW   = 11;
  localparam int BUSY = 40;
  localparam int RDH  = 12;
  localparam int WRH  = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_unlock = 1'b1, arm_req = 1'b0, addr_vld = 1'b0, dat_vld = 1'b0;
  logic commit_req = 1'b0, bad_wr = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] dat_in = '0;
  logic ready_o, wel_o, rd_ok_o, wr_ok_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0] mem_wdata_o;

  always #2 clk = ~clk;

  pgbuf_commit #(.PAGE_BYTES(PG), .ADDR_W(AW), .BUSY_CYC(BUSY),
                 .RD_HOLD_CYC(RDH), .WR_HOLD_CYC(WRH)) u_pgbuf_commit (
    .clk(clk), .rst(rst), .wr_unlock(wr_unlock), .arm_req(arm_req),
    .addr_vld(addr_vld), .addr_in(addr_in), .dat_vld(dat_vld), .dat_in(dat_in),
    .commit_req(commit_req), .bad_wr(bad_wr), .ready_o(ready_o), .wel_o(wel_o),
    .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int m_page, m_ptr, m_have;
  int m_byte [PG];
  int m_v [PG];
  int got_a [64];
  int got_d [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mask();
    for (int i = 0; i < PG; i++) m_v[i] = 0;
  endtask

  task automatic do_arm();
    @(negedge clk); arm_req = 1'b1;
    @(negedge clk); arm_req = 1'b0;
  endtask

  task automatic load_addr(input int a);
    @(negedge clk); addr_in = AW'(a); addr_vld = 1'b1;
    @(negedge clk); addr_vld = 1'b0;
    m_page = a / PG; m_ptr = a % PG; m_have = 1; clear_mask();
  endtask

  task automatic load_byte(input int d);
    @(negedge clk); dat_in = 8'(d); dat_vld = 1'b1;
    @(negedge clk); dat_vld = 1'b0;
    if (m_have != 0) begin
      m_byte[m_ptr] = d; m_v[m_ptr] = 1; m_ptr = (m_ptr + 1) % PG;
    end
  endtask

  task automatic pulse_bad();
    @(negedge clk); bad_wr = 1'b1;
    @(negedge clk); bad_wr = 1'b0;
    clear_mask();
  endtask

  // commit expected to start; collects writes and compares with model
  task automatic commit_run(input int drop_at, input bit poke, input string tag);
    int ng, cnt, ne;
    ng = 0;
    @(negedge clk); commit_req = 1'b1;
    @(negedge clk); commit_req = 1'b0;
    chk(ready_o == 1'b0, {tag, " R6 ready falls"}, int'(ready_o), 0);
    chk(mem_we_o == 1'b0, {tag, " R3 no write yet"}, int'(mem_we_o), 0);
    cnt = 1;
    while (ready_o == 1'b0 && cnt < BUSY + 20) begin
      @(negedge clk);
      if (mem_we_o && ng < 64) begin
        got_a[ng] = int'(mem_addr_o); got_d[ng] = int'(mem_wdata_o); ng++;
      end
      if (!ready_o) cnt++;
      if (drop_at != 0 && cnt == drop_at) wr_unlock = 1'b0;
      addr_in    = AW'(5);
      addr_vld   = poke && cnt == 3;
      dat_vld    = poke && cnt == 5;
      arm_req    = poke && cnt == 7;
      commit_req = poke && cnt == 9;
    end
    addr_vld = 1'b0; dat_vld = 1'b0; arm_req = 1'b0; commit_req = 1'b0;
    chk(cnt == BUSY, {tag, " R6 busy length"}, cnt, BUSY);
    chk(wel_o == 1'b0, {tag, " R6 latch clear at end"}, int'(wel_o), 0);
    ne = 0;
    for (int o = 0; o < PG; o++) begin
      if (m_v[o] != 0) begin
        if (ne < ng) begin
          chk(got_a[ne] == m_page * PG + o, {tag, " R1 write address"}, got_a[ne], m_page * PG + o);
          chk(got_d[ne] == m_byte[o], {tag, " R2 R3 write data"}, got_d[ne], m_byte[o]);
        end
        ne++;
      end
    end
    chk(ng == ne, {tag, " R3 write count"}, ng, ne);
    clear_mask();
  endtask

  task automatic no_commit(input string tag);
    @(negedge clk); commit_req = 1'b1;
    @(negedge clk); commit_req = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(ready_o == 1'b1 && mem_we_o == 1'b0, {tag, " R4 no start"}, int'(ready_o), 1);
      @(negedge clk);
    end
    chk(wel_o == 1'b0, {tag, " R4 latch cleared"}, int'(wel_o), 0);
    clear_mask();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ready_o == 1'b1 && wel_o == 1'b0 && rd_ok_o == 1'b0 && wr_ok_o == 1'b0 && mem_we_o == 1'b0,
        "R11 reset state", int'({ready_o, wel_o, rd_ok_o, wr_ok_o, mem_we_o}), 16);
    rst = 1'b0;
    m_have = 0; m_ptr = 0; m_page = 0; clear_mask();
  endtask

  initial begin
    do_reset();
    // R8: hold-off windows, strobes ignored before write clearance
    for (int n = 1; n <= WRH + 2; n++) begin
      @(negedge clk);
      chk(rd_ok_o == (n >= RDH), "R8 read hold-off", int'(rd_ok_o), int'(n >= RDH));
      chk(wr_ok_o == (n >= WRH), "R8 write hold-off", int'(wr_ok_o), int'(n >= WRH));
      chk(wel_o == 1'b0, "R8 arm ignored before clearance", int'(wel_o), 0);
      if (n == 1) chk(ready_o == 1'b1 && mem_we_o == 1'b0, "R11 first cycle", int'(ready_o), 1);
      arm_req = (n < WRH - 1);
    end
    arm_req = 1'b0;

    // R5: unlock gating of the latch
    wr_unlock = 1'b0;
    do_arm();
    chk(wel_o == 1'b0, "R5 arm with unlock low", int'(wel_o), 0);
    wr_unlock = 1'b1;
    do_arm();
    chk(wel_o == 1'b1, "R5 arm with unlock high", int'(wel_o), 1);
    @(negedge clk); wr_unlock = 1'b0;
    @(negedge clk);
    chk(wel_o == 1'b0, "R5 unlock low clears latch", int'(wel_o), 0);
    wr_unlock = 1'b1;

    // R1 R3: sweep every start offset with varied byte counts
    for (int off = 0; off < PG; off++) begin
      do_arm();
      load_addr(((off * 5 + 3) % 64) * PG + off);
      for (int i = 0; i < (off % 9) + 1; i++) load_byte((off * 37 + i * 11 + 5) & 255);
      commit_run(0, 1'b0, "R1 R3 sweep");
    end

    // R2: load longer than a page wraps
    do_arm();
    load_addr(7 * PG + 29);
    for (int i = 0; i < 40; i++) load_byte((i * 23 + 1) & 255);
    commit_run(0, 1'b0, "R2 wrap");

    // R3: mask cleared at end, offset kept
    do_arm();
    load_byte(8'hA5);
    commit_run(0, 1'b0, "R3 mask cleared");

    // R4: no latch, then discarded mask, then empty page
    load_addr(3 * PG + 4);
    load_byte(17); load_byte(18);
    no_commit("R4 no latch");
    do_arm();
    no_commit("R4 discarded bytes");
    do_arm();
    load_addr(9 * PG);
    no_commit("R4 empty page");

    // R10: strobes during busy ignored
    do_arm();
    load_addr(12 * PG + 10);
    load_byte(1); load_byte(2);
    commit_run(0, 1'b1, "R10 busy strobes");
    do_arm();
    load_byte(99);
    commit_run(0, 1'b0, "R10 state untouched");

    // R7: unlock drop mid-commit
    do_arm();
    load_addr(20 * PG + 0);
    for (int i = 0; i < 4; i++) load_byte(200 + i);
    commit_run(6, 1'b0, "R7 unlock drop");
    chk(wr_unlock == 1'b0, "R7 unlock still low", int'(wr_unlock), 0);
    do_arm();
    load_addr(21 * PG);
    load_byte(3);
    no_commit("R7 later commit blocked");
    wr_unlock = 1'b1;

    // R9: bad_wr
    do_arm();
    load_addr(30 * PG + 2);
    load_byte(44);
    pulse_bad();
    chk(wel_o == 1'b0, "R9 bad write clears latch", int'(wel_o), 0);
    do_arm();
    no_commit("R9 bytes discarded");

    // R9: data before any address after a fresh reset
    do_reset();
    wait (wr_ok_o == 1'b1);
    do_arm();
    chk(wel_o == 1'b1, "R9 armed", int'(wel_o), 1);
    load_byte(7);
    @(negedge clk);
    chk(wel_o == 1'b0, "R9 data without address", int'(wel_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule